// File: doc/BRIEF.md
# Serial Diagnostic Shift Register for an Octal Driver

This block is the serial front end of an eight-channel low-side driver. A host selects the device by pulling an active-low select line. At that moment the block captures eight status bits, one per driver output, into a shift register. Over the serial clock it returns those status bits while accepting new control bits. When the host releases the select line, the block presents the received word on a parallel port with a one-cycle load strobe, for the downstream output latch.

All pins are asynchronous to the block's system clock. They pass through multi-flop synchronizers, and their edges are found on the synchronized levels, so the serial clock has to be several times slower than the system clock. The serial output carries a separate enable, and the pad drives it only while the device is selected.

Because any number of bits may be clocked through in one select period, identical devices can be chained. The output of one feeds the input of the next, and each device keeps the last eight bits it received.

Top module: `spi_diag_shifter`

## Requirements
- R1: On the detected falling edge of the select pin, the shift register takes `diag_in` in parallel. Bit i is 1 when driver output i is high and 0 when it is low.
- R2: `sdo_oe` is 1 only while the synchronized select is low. While deselected, `sdo` reads 0.
- R3: A new bit is placed on `sdo` after each rising serial-clock edge. `sdi` is sampled on each falling serial-clock edge, never on the rising one.
- R4: Both directions are most significant bit first. After the first rising serial-clock edge of a select period, `sdo` shows `diag_in[7]` as captured in R1.
- R5: On the detected rising edge of the select pin, `latch_load` is 1 for exactly one system clock. In that same cycle `latch_data` holds the shift register contents, and `latch_data` keeps that value until the next strobe.
- R6: Any number of bits may be shifted in one select period. A bit received on `sdi` leaves on `sdo` eight rising edges later, and the last eight bits received are the ones handed to `latch_data`.
- R7: Serial-clock edges seen while deselected have no effect. `sdo` keeps the last bit it drove until the next rising serial-clock edge of a select period, and no strobe is produced.
- R8: After reset, `sdo_oe`, `sdo`, `latch_load` and `latch_data` are all 0, and the block treats itself as deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_pin | input | 1 | Asynchronous active-low device select |
| sclk_pin | input | 1 | Asynchronous serial clock |
| sdi_pin | input | 1 | Asynchronous serial data in |
| diag_in | input | WIDTH | Per-output status levels, 1 means output high |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Tri-state enable for the serial output pad |
| latch_data | output | WIDTH | Word handed to the output latch |
| latch_load | output | 1 | One-cycle strobe that qualifies `latch_data` |

## Verification
The bench builds the block with its default values: an 8-bit word and two synchronizer stages. Serial half-periods are eight system clocks, so each pin change passes the synchronizer and edge detector well before the next one. With these values the bench can run single-byte frames with different status and control patterns, and a 16-bit chained frame in which the first byte received comes back out on `sdo`. It also covers a select period with no clocks at all, and serial-clock toggling while the device is deselected.

// File: rtl/spi_diag_pkg.sv
// Package: shared constants for the serial diagnostic shift register.
// Assumes: pin bundle ordering below is used by every module of the block.
package spi_diag_pkg;

    // Number of asynchronous pins brought into the system clock domain.
    localparam int unsigned PIN_CNT = 3;

    // Bit positions of each pin inside the synchronized bundle.
    localparam int unsigned PIN_SEL  = 0;
    localparam int unsigned PIN_SCLK = 1;
    localparam int unsigned PIN_SDI  = 2;

    // Idle levels of the pins, used as reset values of the synchronizers.
    localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b001;

    // Edge events of a single synchronized pin.
    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes: each pin is a slow level signal; no bus coherency is required
// between pins, because the sampling relation is kept by equal stage counts.
module spi_pin_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    logic [N-1:0] stage_q [STAGES];

    // Shift every pin through the chain of flops, idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/spi_edge_detect.sv
// Module: rise/fall detector for a bundle of synchronized levels.
// Assumes: inputs are already in the clk domain; the outputs are combinational
// and valid for the single cycle after a level change reaches the input.
module spi_edge_detect #(
    parameter int unsigned N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            level,
    output spi_diag_pkg::pin_edge_t edges [N]
);

    logic [N-1:0] prev_q;

    // Remember last cycle's level of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign edges[i].rise = level[i] & ~prev_q[i];
        assign edges[i].fall = ~level[i] & prev_q[i];
    end

endmodule

// File: rtl/spi_diag_shreg.sv
// Module: shift register with parallel status load, MSB-first serial output
// updated on serial-clock rise, serial input sampled on serial-clock fall,
// and a parallel hand-off with a one-cycle strobe at the end of selection.
// Assumes: all event inputs are single-cycle pulses in the clk domain;
// a select start wins over a serial-clock event in the same cycle.
module spi_diag_shreg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             selected,
    input  logic             sel_start,
    input  logic             sel_end,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             sdi_bit,
    input  logic [WIDTH-1:0] diag_in,
    output logic [WIDTH-1:0] sr_q,
    output logic             sdo_q,
    output logic [WIDTH-1:0] latch_data,
    output logic             latch_load
);

    localparam int unsigned MSB = WIDTH - 1;

    logic shift_in_en;
    logic shift_out_en;

    // Serial events count only inside a select period and not on its first cycle.
    assign shift_in_en  = selected & sclk_fall & ~sel_start;
    assign shift_out_en = selected & sclk_rise & ~sel_start;

    // Capture status at select start, otherwise shift in on falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sel_start) begin
            sr_q <= diag_in;
        end else if (shift_in_en) begin
            sr_q <= {sr_q[MSB-1:0], sdi_bit};
        end
    end

    // Present the MSB on the serial output after each rising serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (shift_out_en) begin
            sdo_q <= sr_q[MSB];
        end
    end

    // Hand the received word to the latch with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_data <= '0;
            latch_load <= 1'b0;
        end else begin
            latch_load <= sel_end;
            if (sel_end) begin
                latch_data <= sr_q;
            end
        end
    end

endmodule

// File: rtl/spi_diag_shifter.sv
// Module: top of the serial diagnostic shift register.
// Synchronizes the select, serial clock and serial data pins, finds their
// edges, and drives the shift register and the serial output enable.
// Assumes: serial half-periods last several system clocks (at least
// SYNC_STAGES + 2) and diag_in is stable in the clk domain.
module spi_diag_shifter #(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_pin,
    input  logic             sclk_pin,
    input  logic             sdi_pin,
    input  logic [WIDTH-1:0] diag_in,
    output logic             sdo,
    output logic             sdo_oe,
    output logic [WIDTH-1:0] latch_data,
    output logic             latch_load
);

    import spi_diag_pkg::*;

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_sync;
    pin_edge_t          pin_edges [PIN_CNT];

    logic             sel_sync;
    logic             sdi_sync;
    logic             sel_fall;
    logic             sel_rise;
    logic             sclk_rise;
    logic             sclk_fall;
    logic [WIDTH-1:0] sr_q;
    logic             sdo_q;

    assign pins_raw[PIN_SEL]  = sel_n_pin;
    assign pins_raw[PIN_SCLK] = sclk_pin;
    assign pins_raw[PIN_SDI]  = sdi_pin;

    spi_pin_sync #(
        .N       (PIN_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_sync)
    );

    spi_edge_detect #(
        .N       (PIN_CNT),
        .RST_VAL (PIN_IDLE)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pins_sync),
        .edges (pin_edges)
    );

    assign sel_sync  = pins_sync[PIN_SEL];
    assign sdi_sync  = pins_sync[PIN_SDI];
    assign sel_fall  = pin_edges[PIN_SEL].fall;
    assign sel_rise  = pin_edges[PIN_SEL].rise;
    assign sclk_rise = pin_edges[PIN_SCLK].rise;
    assign sclk_fall = pin_edges[PIN_SCLK].fall;

    spi_diag_shreg #(
        .WIDTH (WIDTH)
    ) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .selected   (~sel_sync),
        .sel_start  (sel_fall),
        .sel_end    (sel_rise),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sdi_bit    (sdi_sync),
        .diag_in    (diag_in),
        .sr_q       (sr_q),
        .sdo_q      (sdo_q),
        .latch_data (latch_data),
        .latch_load (latch_load)
    );

    // Pad enable follows the synchronized select; data is quiet when off.
    assign sdo_oe = ~sel_sync;
    assign sdo    = sdo_q & sdo_oe;

endmodule

// File: rtl/spi_diag_checker.sv
// Module: property checker for spi_diag_shifter, attached by bind.
// Assumes: connected to the top's internal event and state signals.
module spi_diag_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_sync,
    input logic             sel_fall,
    input logic             sel_rise,
    input logic             sclk_rise,
    input logic             sclk_fall,
    input logic             sdi_sync,
    input logic [WIDTH-1:0] diag_in,
    input logic [WIDTH-1:0] sr_q,
    input logic             sdo_q,
    input logic             sdo_oe,
    input logic [WIDTH-1:0] latch_data,
    input logic             latch_load
);

    AST_PARALLEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fall |=> sr_q == $past(diag_in)); // R1

    AST_OE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> sel_fall); // R2

    AST_SAMPLE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !sel_sync && !sel_fall) |=> sr_q[0] == $past(sdi_sync)); // R3

    AST_MSB_FIRST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !sel_sync && !sel_fall) |=> sdo_q == $past(sr_q[WIDTH-1])); // R4

    AST_STROBE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_load |-> $past(sel_rise)); // R5

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_load |=> !latch_load); // R5

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_load |-> $stable(latch_data)); // R5

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sync && $past(sel_sync)) |-> ($stable(sr_q) && $stable(sdo_q))); // R7

endmodule

bind spi_diag_shifter spi_diag_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_sync   (sel_sync),
    .sel_fall   (sel_fall),
    .sel_rise   (sel_rise),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sdi_sync   (sdi_sync),
    .diag_in    (diag_in),
    .sr_q       (sr_q),
    .sdo_q      (sdo_q),
    .sdo_oe     (sdo_oe),
    .latch_data (latch_data),
    .latch_load (latch_load)
);

// File: tb/test_spi_diag_shifter.sv
module test_spi_diag_shifter;

    localparam int unsigned WIDTH = 8;
    localparam int unsigned HALF  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sel_n_pin = 1'b1;
    logic             sclk_pin = 1'b0;
    logic             sdi_pin = 1'b0;
    logic [WIDTH-1:0] diag_in = '0;
    logic             sdo;
    logic             sdo_oe;
    logic [WIDTH-1:0] latch_data;
    logic             latch_load;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    spi_diag_shifter #(.WIDTH(WIDTH), .SYNC_STAGES(2)) i_spi_diag_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_pin  (sel_n_pin),
        .sclk_pin   (sclk_pin),
        .sdi_pin    (sdi_pin),
        .diag_in    (diag_in),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .latch_data (latch_data),
        .latch_load (latch_load)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One serial bit: rise, read sdo, drive next sdi, fall.
    task automatic shift_bit(input logic b, output logic so);
        sclk_pin = 1'b1;
        tick(HALF);
        so = sdo;
        sdi_pin = b;
        tick(HALF / 2);
        sclk_pin = 1'b0;
        tick(HALF);
    endtask

    // Release select and watch for the strobe.
    task automatic release_sel(output int pulses, output logic [WIDTH-1:0] word);
        pulses = 0;
        word = '0;
        sel_n_pin = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (latch_load) begin
                pulses++;
                word = latch_data;
            end
        end
    endtask

    task automatic t_reset();
        check(sdo_oe == 1'b0, "R8 sdo_oe", {31'b0, sdo_oe}, 0);
        check(sdo == 1'b0, "R8 sdo", {31'b0, sdo}, 0);
        check(latch_load == 1'b0, "R8 latch_load", {31'b0, latch_load}, 0);
        check(latch_data == '0, "R8 latch_data", {24'b0, latch_data}, 0);
    endtask

    // Single-byte frame: status out, control in, latched on release.
    task automatic t_frame(input logic [WIDTH-1:0] diag, input logic [WIDTH-1:0] ctl);
        logic [WIDTH-1:0] rx;
        logic so;
        int pulses;
        logic [WIDTH-1:0] word;
        diag_in = diag;
        sel_n_pin = 1'b0;
        tick(HALF);
        check(sdo_oe == 1'b1, "R2 oe while selected", {31'b0, sdo_oe}, 1);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            shift_bit(ctl[i], so);
            rx[i] = so;
            if (i == WIDTH - 1) begin
                check(so == diag[WIDTH-1], "R4 first bit is status MSB", {31'b0, so},
                      {31'b0, diag[WIDTH-1]});
            end
        end
        check(rx == diag, "R1 R3 status read back", {24'b0, rx}, {24'b0, diag});
        release_sel(pulses, word);
        check(pulses == 1, "R5 one strobe", pulses, 1);
        check(word == ctl, "R3 R5 latched control", {24'b0, word}, {24'b0, ctl});
        check(sdo_oe == 1'b0 && sdo == 1'b0, "R2 off after release",
              {30'b0, sdo_oe, sdo}, 0);
        check(latch_data == ctl, "R5 latch held", {24'b0, latch_data}, {24'b0, ctl});
    endtask

    // Chained frame of 16 bits: first byte passes through to sdo.
    task automatic t_chain();
        logic [2*WIDTH-1:0] tx;
        logic [2*WIDTH-1:0] rx;
        logic so;
        int pulses;
        logic [WIDTH-1:0] word;
        tx = 16'h553C;
        diag_in = 8'h81;
        sel_n_pin = 1'b0;
        tick(HALF);
        for (int i = 2 * WIDTH - 1; i >= 0; i--) begin
            shift_bit(tx[i], so);
            rx[i] = so;
        end
        check(rx[15:8] == 8'h81, "R6 status first", {24'b0, rx[15:8]}, 32'h81);
        check(rx[7:0] == 8'h55, "R6 pass-through", {24'b0, rx[7:0]}, 32'h55);
        release_sel(pulses, word);
        check(pulses == 1 && word == 8'h3C, "R6 last eight latched",
              {24'b0, word}, 32'h3C);
    endtask

    // Serial clocks while deselected: no strobe, sdo keeps last bit (1).
    task automatic t_ignore();
        int pulses;
        logic [WIDTH-1:0] word;
        pulses = 0;
        for (int i = 0; i < 3; i++) begin
            sdi_pin = ~sdi_pin;
            sclk_pin = 1'b1;
            for (int k = 0; k < HALF; k++) begin
                tick(1);
                if (latch_load) pulses++;
            end
            sclk_pin = 1'b0;
            for (int k = 0; k < HALF; k++) begin
                tick(1);
                if (latch_load) pulses++;
            end
        end
        check(pulses == 0, "R7 no strobe while idle", pulses, 0);
        diag_in = 8'h00;
        sel_n_pin = 1'b0;
        tick(HALF);
        check(sdo == 1'b1, "R7 sdo kept last bit", {31'b0, sdo}, 1);
        release_sel(pulses, word);
        check(pulses == 1 && word == 8'h00, "R1 R5 no-clock frame latches status",
              {24'b0, word}, 0);
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_frame(8'hA5, 8'h3C);
        t_frame(8'h0F, 8'hF0);
        t_frame(8'h60, 8'h81);
        t_chain();
        t_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule